// File: doc/BRIEF.md
# Eighteen-Function Integer ALU with Carry and Overflow Flags

This block is a purely combinational arithmetic logic unit of parameterised width. A 5-bit function code picks one of eighteen operations on two operands `opnd_x` and `opnd_y`. The operations are:

- constants;
- pass-through and bitwise inversion of either operand;
- negation, increment and decrement of either operand;
- addition and subtraction in both orders;
- bitwise AND and OR.

The block returns a result as wide as the operands, together with four status flags.

Every arithmetic function goes through one shared ripple-carry adder. Each stage of that adder is a full adder made of two half adders and an OR gate. Subtraction and negation invert one adder input and force the initial carry-in to 1. Increment adds the constant +1. Decrement adds the all-ones value. The unsigned flag is the raw carry out of the top stage. The signed flag compares the carry into the top stage with the carry out of it. The zero and negative flags describe the result itself.

Top module: `arith_logic_unit`

## Requirements
- R1: Function codes select operations as follows: 0 gives 0, 1 gives 1, 2 gives all ones (-1), 3 gives x, 4 gives y, 5 gives NOT x, 6 gives NOT y, 16 gives x AND y, and 17 gives x OR y.
- R2: The arithmetic codes give results modulo 2^WIDTH, that is, the low WIDTH bits of the exact value. The codes are: 7 (-x), 8 (-y), 9 (x+1), 10 (y+1), 11 (x-1), 12 (y-1), 13 (x+y), 14 (x-y) and 15 (y-x).
- R3: For codes 9 to 13, `flag_carry` equals the carry out of the top bit of the unsigned sum. For x+y this means x+y > 2^WIDTH-1. For x+1 it means x is all ones. For x-1, which is computed as x plus all ones, it means x is not zero.
- R4: For codes 7, 8, 14 and 15, `flag_carry` is the raw adder carry-out, where 1 means no borrow. For a-b it is 1 exactly when a >= b as unsigned values. For a negation it is 1 exactly when the operand is zero.
- R5: For codes 7 to 15, `flag_ovf` is 1 exactly when the exact signed two's-complement result lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R6: For codes 0 to 6, 16 and 17, `flag_carry` and `flag_ovf` are both 0.
- R7: For codes 0 to 17, `flag_zero` is 1 exactly when the result is all zeros, and `flag_neg` equals the result's top bit.
- R8: Codes 18 to 31 give a result of 0 with all four flags at 0, including `flag_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | WIDTH | First operand |
| opnd_y | input | WIDTH | Second operand |
| func_sel | input | 5 | Function code, 0 to 17 legal |
| result | output | WIDTH | Low WIDTH bits of the selected function |
| flag_carry | output | 1 | Unsigned carry out of the top adder stage |
| flag_ovf | output | 1 | Signed two's-complement overflow |
| flag_zero | output | 1 | Result is all zeros (legal codes only) |
| flag_neg | output | 1 | Top bit of the result (legal codes only) |

## Verification
The hardest cases to reach are the single operand values at which a one-operand function overflows as a signed value. Negating the most negative value, decrementing it, and incrementing the most positive value each have exactly one triggering input. Negating zero is the only negation that reports no borrow. Random stimulus rarely lands on these inputs. The bench therefore sweeps every operand pair under all 32 function codes, at both 4 and 8 bits, so that each of these single points is applied. It compares every output against an integer model that computes the exact signed and unsigned values.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    localparam int SEL_W    = 5;
    localparam int FN_COUNT = 18;

    typedef enum logic [SEL_W-1:0] {
        FN_ZERO   = 5'd0,
        FN_ONE    = 5'd1,
        FN_ONES   = 5'd2,
        FN_PASS_X = 5'd3,
        FN_PASS_Y = 5'd4,
        FN_NOT_X  = 5'd5,
        FN_NOT_Y  = 5'd6,
        FN_NEG_X  = 5'd7,
        FN_NEG_Y  = 5'd8,
        FN_INC_X  = 5'd9,
        FN_INC_Y  = 5'd10,
        FN_DEC_X  = 5'd11,
        FN_DEC_Y  = 5'd12,
        FN_ADD    = 5'd13,
        FN_SUB_XY = 5'd14,
        FN_SUB_YX = 5'd15,
        FN_AND    = 5'd16,
        FN_OR     = 5'd17
    } alu_fn_e;

    typedef enum logic [1:0] {
        ASRC_X,
        ASRC_Y,
        ASRC_ZERO
    } a_src_e;

    typedef enum logic [1:0] {
        BSRC_X,
        BSRC_Y,
        BSRC_ONE,
        BSRC_ONES
    } b_src_e;

    typedef enum logic [3:0] {
        LOG_ZERO,
        LOG_ONE,
        LOG_ONES,
        LOG_X,
        LOG_Y,
        LOG_NOT_X,
        LOG_NOT_Y,
        LOG_AND,
        LOG_OR
    } logic_op_e;

    typedef struct packed {
        logic      legal;
        logic      use_adder;
        a_src_e    a_src;
        b_src_e    b_src;
        logic      invert_b;
        logic      carry_in;
        logic_op_e log_op;
    } alu_ctrl_t;

    function automatic logic fn_is_legal(input logic [SEL_W-1:0] code);
        return code < SEL_W'(FN_COUNT);
    endfunction

endpackage

// File: rtl/alu_half_adder.sv
`timescale 1ns/1ps
module alu_half_adder (
    input  logic in_a,
    input  logic in_b,
    output logic sum,
    output logic carry
);
    assign sum   = in_a ^ in_b;
    assign carry = in_a & in_b;
endmodule

// File: rtl/alu_full_adder.sv
`timescale 1ns/1ps
module alu_full_adder (
    input  logic in_a,
    input  logic in_b,
    input  logic cin,
    output logic sum,
    output logic cout
);
    logic part_sum;
    logic part_c0;
    logic part_c1;

    alu_half_adder u_ha_lo (
        .in_a  (in_a),
        .in_b  (in_b),
        .sum   (part_sum),
        .carry (part_c0)
    );

    alu_half_adder u_ha_hi (
        .in_a  (part_sum),
        .in_b  (cin),
        .sum   (sum),
        .carry (part_c1)
    );

    assign cout = part_c0 | part_c1;
endmodule

// File: rtl/alu_ripple_adder.sv
`timescale 1ns/1ps
module alu_ripple_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] add_a,
    input  logic [WIDTH-1:0] add_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             carry_into_msb
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        alu_full_adder u_fa (
            .in_a (add_a[i]),
            .in_b (add_b[i]),
            .cin  (chain[i]),
            .sum  (sum[i]),
            .cout (chain[i+1])
        );
    end

    assign cout           = chain[WIDTH];
    assign carry_into_msb = chain[MSB];
endmodule

// File: rtl/alu_decode.sv
`timescale 1ns/1ps
module alu_decode
    import alu_pkg::*;
(
    input  logic [SEL_W-1:0] func_sel,
    output alu_ctrl_t        ctrl
);
    always_comb begin
        ctrl           = '0;
        ctrl.legal     = fn_is_legal(func_sel);
        ctrl.use_adder = 1'b0;
        ctrl.a_src     = ASRC_ZERO;
        ctrl.b_src     = BSRC_Y;
        ctrl.invert_b  = 1'b0;
        ctrl.carry_in  = 1'b0;
        ctrl.log_op    = LOG_ZERO;
        case (func_sel)
            FN_ZERO:   ctrl.log_op = LOG_ZERO;
            FN_ONE:    ctrl.log_op = LOG_ONE;
            FN_ONES:   ctrl.log_op = LOG_ONES;
            FN_PASS_X: ctrl.log_op = LOG_X;
            FN_PASS_Y: ctrl.log_op = LOG_Y;
            FN_NOT_X:  ctrl.log_op = LOG_NOT_X;
            FN_NOT_Y:  ctrl.log_op = LOG_NOT_Y;
            FN_AND:    ctrl.log_op = LOG_AND;
            FN_OR:     ctrl.log_op = LOG_OR;
            FN_NEG_X: begin
                ctrl.use_adder = 1'b1;
                ctrl.a_src     = ASRC_ZERO;
                ctrl.b_src     = BSRC_X;
                ctrl.invert_b  = 1'b1;
                ctrl.carry_in  = 1'b1;
            end
            FN_NEG_Y: begin
                ctrl.use_adder = 1'b1;
                ctrl.a_src     = ASRC_ZERO;
                ctrl.b_src     = BSRC_Y;
                ctrl.invert_b  = 1'b1;
                ctrl.carry_in  = 1'b1;
            end
            FN_INC_X: begin
                ctrl.use_adder = 1'b1;
                ctrl.a_src     = ASRC_X;
                ctrl.b_src     = BSRC_ONE;
            end
            FN_INC_Y: begin
                ctrl.use_adder = 1'b1;
                ctrl.a_src     = ASRC_Y;
                ctrl.b_src     = BSRC_ONE;
            end
            FN_DEC_X: begin
                ctrl.use_adder = 1'b1;
                ctrl.a_src     = ASRC_X;
                ctrl.b_src     = BSRC_ONES;
            end
            FN_DEC_Y: begin
                ctrl.use_adder = 1'b1;
                ctrl.a_src     = ASRC_Y;
                ctrl.b_src     = BSRC_ONES;
            end
            FN_ADD: begin
                ctrl.use_adder = 1'b1;
                ctrl.a_src     = ASRC_X;
                ctrl.b_src     = BSRC_Y;
            end
            FN_SUB_XY: begin
                ctrl.use_adder = 1'b1;
                ctrl.a_src     = ASRC_X;
                ctrl.b_src     = BSRC_Y;
                ctrl.invert_b  = 1'b1;
                ctrl.carry_in  = 1'b1;
            end
            FN_SUB_YX: begin
                ctrl.use_adder = 1'b1;
                ctrl.a_src     = ASRC_Y;
                ctrl.b_src     = BSRC_X;
                ctrl.invert_b  = 1'b1;
                ctrl.carry_in  = 1'b1;
            end
            default: ctrl.log_op = LOG_ZERO;
        endcase
    end
endmodule

// File: rtl/alu_operand_prep.sv
`timescale 1ns/1ps
module alu_operand_prep
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    input  alu_ctrl_t        ctrl,
    output logic [WIDTH-1:0] add_a,
    output logic [WIDTH-1:0] add_b,
    output logic             cin
);
    localparam logic [WIDTH-1:0] ONE_W = WIDTH'(1);

    logic [WIDTH-1:0] b_raw;

    always_comb begin
        case (ctrl.a_src)
            ASRC_X:  add_a = opnd_x;
            ASRC_Y:  add_a = opnd_y;
            default: add_a = '0;
        endcase
        case (ctrl.b_src)
            BSRC_X:    b_raw = opnd_x;
            BSRC_Y:    b_raw = opnd_y;
            BSRC_ONE:  b_raw = ONE_W;
            default:   b_raw = '1;
        endcase
        add_b = ctrl.invert_b ? ~b_raw : b_raw;
        cin   = ctrl.carry_in;
    end
endmodule

// File: rtl/alu_logic_unit.sv
`timescale 1ns/1ps
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    input  logic_op_e        log_op,
    output logic [WIDTH-1:0] log_out
);
    localparam logic [WIDTH-1:0] ONE_W = WIDTH'(1);

    always_comb begin
        case (log_op)
            LOG_ONE:   log_out = ONE_W;
            LOG_ONES:  log_out = '1;
            LOG_X:     log_out = opnd_x;
            LOG_Y:     log_out = opnd_y;
            LOG_NOT_X: log_out = ~opnd_x;
            LOG_NOT_Y: log_out = ~opnd_y;
            LOG_AND:   log_out = opnd_x & opnd_y;
            LOG_OR:    log_out = opnd_x | opnd_y;
            default:   log_out = '0;
        endcase
    end
endmodule

// File: rtl/arith_logic_unit.sv
`timescale 1ns/1ps
module arith_logic_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    input  logic [4:0]       func_sel,
    output logic [WIDTH-1:0] result,
    output logic             flag_carry,
    output logic             flag_ovf,
    output logic             flag_zero,
    output logic             flag_neg
);
    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] add_a;
    logic [WIDTH-1:0] add_b;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic             add_c_msb;
    logic [WIDTH-1:0] log_out;

    alu_decode u_decode (
        .func_sel (func_sel),
        .ctrl     (ctrl)
    );

    alu_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .opnd_x (opnd_x),
        .opnd_y (opnd_y),
        .ctrl   (ctrl),
        .add_a  (add_a),
        .add_b  (add_b),
        .cin    (add_cin)
    );

    alu_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .add_a          (add_a),
        .add_b          (add_b),
        .cin            (add_cin),
        .sum            (add_sum),
        .cout           (add_cout),
        .carry_into_msb (add_c_msb)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .opnd_x  (opnd_x),
        .opnd_y  (opnd_y),
        .log_op  (ctrl.log_op),
        .log_out (log_out)
    );

    always_comb begin
        result     = ctrl.use_adder ? add_sum : log_out;
        flag_carry = ctrl.use_adder & add_cout;
        flag_ovf   = ctrl.use_adder & (add_cout ^ add_c_msb);
        flag_zero  = ctrl.legal & ~(|result);
        flag_neg   = ctrl.legal & result[MSB];
    end
endmodule

// File: rtl/alu_checker.sv
`timescale 1ns/1ps
module alu_checker
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] opnd_x,
    input logic [WIDTH-1:0] opnd_y,
    input logic [4:0]       func_sel,
    input logic [WIDTH-1:0] result,
    input logic             flag_carry,
    input logic             flag_ovf,
    input logic             flag_zero,
    input logic             flag_neg
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide_sum;
    logic [WIDTH:0] wide_dif;
    logic           is_logic_fn;

    always_comb begin
        wide_sum    = {1'b0, opnd_x} + {1'b0, opnd_y};
        wide_dif    = {1'b0, opnd_x} - {1'b0, opnd_y};
        is_logic_fn = (func_sel <= 5'd6) || (func_sel == 5'd16) || (func_sel == 5'd17);

        if (func_sel == 5'd13)
            AST_ADD_WIDE_SUM: assert ({flag_carry, result} == wide_sum) else $error("add sum/carry"); // R3
        if (func_sel == 5'd14)
            AST_SUB_NO_BORROW: assert (result == wide_dif[MSB:0] && flag_carry == (opnd_x >= opnd_y)) else $error("sub borrow"); // R4
        if (func_sel == 5'd13)
            AST_ADD_SIGNED_OVF: assert (flag_ovf == ((opnd_x[MSB] == opnd_y[MSB]) && (result[MSB] != opnd_x[MSB]))) else $error("add ovf"); // R5
        if (is_logic_fn)
            AST_LOGIC_NO_OVERFLOW: assert (!flag_carry && !flag_ovf) else $error("logic flags"); // R6
        AST_ZERO_NOT_NEG: assert (!(flag_zero && flag_neg)) else $error("zero and neg"); // R7
        if (func_sel >= 5'd18)
            AST_ILLEGAL_QUIET: assert (result == '0 && !flag_carry && !flag_ovf && !flag_zero && !flag_neg) else $error("illegal code"); // R8
    end
endmodule

bind arith_logic_unit alu_checker #(.WIDTH(WIDTH)) u_alu_checker (
    .opnd_x     (opnd_x),
    .opnd_y     (opnd_y),
    .func_sel   (func_sel),
    .result     (result),
    .flag_carry (flag_carry),
    .flag_ovf   (flag_ovf),
    .flag_zero  (flag_zero),
    .flag_neg   (flag_neg)
);

// File: tb/arith_logic_unit_bench.sv
`timescale 1ns/1ps
module arith_logic_unit_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int cycles = 0;

    logic [3:0] x4, y4, r4;
    logic [7:0] x8, y8, r8;
    logic [4:0] s4, s8;
    logic c4, v4, z4, n4, c8, v8, z8, n8;

    arith_logic_unit #(.WIDTH(4)) u_arith_logic_unit_w4 (
        .opnd_x(x4), .opnd_y(y4), .func_sel(s4), .result(r4),
        .flag_carry(c4), .flag_ovf(v4), .flag_zero(z4), .flag_neg(n4)
    );

    arith_logic_unit #(.WIDTH(8)) u_arith_logic_unit (
        .opnd_x(x8), .opnd_y(y8), .func_sel(s8), .result(r8),
        .flag_carry(c8), .flag_ovf(v8), .flag_zero(z8), .flag_neg(n8)
    );

    task automatic check(input int w, input int sel, input int x, input int y,
                         input int r, input bit c, input bit v, input bit z, input bit n);
        int  mask  = (1 << w) - 1;
        int  top   = 1 << (w - 1);
        int  sx    = (x >= top) ? x - (1 << w) : x;
        int  sy    = (y >= top) ? y - (1 << w) : y;
        int  t     = 0;
        int  st    = 0;
        bit  arith = 1'b1;
        bit  ec    = 1'b0;
        bit  ev, ez, en, bad;
        int  er;
        string rt, ct, vt, ft;
        case (sel)
            0:  begin arith = 0; t = 0; end
            1:  begin arith = 0; t = 1; end
            2:  begin arith = 0; t = -1; end
            3:  begin arith = 0; t = x; end
            4:  begin arith = 0; t = y; end
            5:  begin arith = 0; t = ~x; end
            6:  begin arith = 0; t = ~y; end
            7:  begin t = -x; st = -sx; ec = (x == 0); end
            8:  begin t = -y; st = -sy; ec = (y == 0); end
            9:  begin t = x + 1; st = sx + 1; ec = (x + 1 > mask); end
            10: begin t = y + 1; st = sy + 1; ec = (y + 1 > mask); end
            11: begin t = x - 1; st = sx - 1; ec = (x != 0); end
            12: begin t = y - 1; st = sy - 1; ec = (y != 0); end
            13: begin t = x + y; st = sx + sy; ec = (x + y > mask); end
            14: begin t = x - y; st = sx - sy; ec = (x >= y); end
            15: begin t = y - x; st = sy - sx; ec = (y >= x); end
            16: begin arith = 0; t = x & y; end
            17: begin arith = 0; t = x | y; end
            default: begin arith = 0; t = 0; end
        endcase
        er = t & mask;
        ev = arith && (st < -top || st > top - 1);
        ez = (sel < 18) && (er == 0);
        en = (sel < 18) && ((er & top) != 0);
        ft = (sel >= 18) ? "R8" : "R7";
        rt = (sel >= 18) ? "R8" : (arith ? "R2" : "R1");
        ct = (sel >= 18) ? "R8" : (!arith ? "R6" :
             ((sel == 7 || sel == 8 || sel == 14 || sel == 15) ? "R4" : "R3"));
        vt = (sel >= 18) ? "R8" : (arith ? "R5" : "R6");
        n_vec++;
        bad = 1'b0;
        if (r != er) begin bad = 1; $display("FAIL %s w=%0d sel=%0d x=%0d y=%0d result=%0d expected %0d", rt, w, sel, x, y, r, er); end
        if (c != ec) begin bad = 1; $display("FAIL %s w=%0d sel=%0d x=%0d y=%0d carry=%0d expected %0d", ct, w, sel, x, y, c, ec); end
        if (v != ev) begin bad = 1; $display("FAIL %s w=%0d sel=%0d x=%0d y=%0d ovf=%0d expected %0d", vt, w, sel, x, y, v, ev); end
        if (z != ez) begin bad = 1; $display("FAIL %s w=%0d sel=%0d x=%0d y=%0d zero=%0d expected %0d", ft, w, sel, x, y, z, ez); end
        if (n != en) begin bad = 1; $display("FAIL %s w=%0d sel=%0d x=%0d y=%0d neg=%0d expected %0d", ft, w, sel, x, y, n, en); end
        if (bad) n_fail++;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            n_fail++;
            finish_run();
        end
    end

    initial begin
        x4 = '0; y4 = '0; s4 = '0;
        x8 = '0; y8 = '0; s8 = '0;
        #5;
        // R1 R2 R3 R4 R5 R6 R7 R8: exhaustive sweep at 4 bits
        for (int s = 0; s < 32; s++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    s4 = 5'(s); x4 = 4'(a); y4 = 4'(b);
                    #0.005;
                    check(4, s, a, b, int'(r4), c4, v4, z4, n4);
                    #0.005;
                end
        // Same sweep at 8 bits, including the single overflow points of -x, x-1, x+1
        for (int s = 0; s < 32; s++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++) begin
                    s8 = 5'(s); x8 = 8'(a); y8 = 8'(b);
                    #0.005;
                    check(8, s, a, b, int'(r8), c8, v8, z8, n8);
                    #0.005;
                end
        finish_run();
    end

endmodule